// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a program's segment-relative address into a physical address. A request names a segment through a selector, gives an offset inside that segment and says what kind of access it is: a data read, a data write or an instruction fetch. The selector picks one entry of a small on-chip descriptor table. Each entry holds the segment's start address, its highest legal offset and its permissions. If the access is allowed, the block returns the start address plus the offset. If it is not, the block returns a fault with a cause code and no address.

A supervisor loads the table through a write port, one descriptor per cycle. Requests and responses each use a valid/ready handshake. The result is registered, so it appears one cycle after the request is accepted, and it stays on the outputs until the consumer takes it. Reset leaves every descriptor marked unusable, so nothing can be translated until the supervisor has loaded the table.

Top module: `seg_xlate`

## Requirements
- R1: For an accepted request with no fault, the response carries `rsp_fault`=0, `rsp_cause`=0 and `rsp_addr` = descriptor start address + zero-extended offset, modulo 2^BASE_W.
- R2: An offset strictly greater than the descriptor's limit gives `rsp_cause`=2 (limit fault). An offset equal to the limit is legal.
- R3: `req_acc` encodes 0 = read, 1 = write, 2 = fetch and 3 = reserved. `wr_perm` bit 0 allows reads, bit 1 allows writes and bit 2 allows fetches. An access whose permission bit is clear, or any access with code 3, gives `rsp_cause`=3 (permission fault).
- R4: A selector that names a descriptor with its valid flag clear gives `rsp_cause`=1. When more than one fault applies, the cause reported follows the priority invalid > limit > permission.
- R5: Reset clears every descriptor's valid flag and `rsp_valid`. After reset, any request on any selector gives `rsp_cause`=1.
- R6: The response appears in the cycle after a `req_valid`/`req_ready` handshake. While `rsp_valid`=1 and `rsp_ready`=0, the response stays valid and unchanged.
- R7: `req_ready` is 1 exactly when there is no pending response or the pending response is being taken in that cycle (`rsp_ready`=1). A request offered while `req_ready`=0 is not accepted and does not change the response.
- R8: With `wr_en`=1 the write port replaces the descriptor at `wr_sel` (valid flag, permissions, start address, limit) at the clock edge. A request accepted in that same cycle for that selector sees the old contents. Writing `wr_valid`=0 makes the descriptor invalid.
- R9: Whenever `rsp_valid`=1, `rsp_fault` is 1 exactly when `rsp_cause` is nonzero, and a faulted response carries `rsp_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_sel | input | SEL_W | Segment selector |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 fetch, 3 reserved) |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | BASE_W | Physical address, 0 when faulted |
| rsp_fault | output | 1 | Access faulted |
| rsp_cause | output | 2 | 0 none, 1 invalid descriptor, 2 limit, 3 permission |
| wr_en | input | 1 | Descriptor write strobe |
| wr_sel | input | SEL_W | Descriptor to write |
| wr_valid | input | 1 | New valid flag |
| wr_perm | input | 3 | New permissions (bit0 read, bit1 write, bit2 fetch) |
| wr_base | input | BASE_W | New segment start address |
| wr_bound | input | OFF_W | New highest legal offset |

## Verification
The bench sends directed requests with offsets below the limit, equal to it and one above it, on segments that allow only a single access type. This separates the limit comparison from the permission decode and shows the fault priority when both apply. A segment that starts near the top of the address space shows that the sum wraps. A long phase of random requests, random consumer back-pressure and random descriptor writes then runs against a behavioural model. It covers stalled responses, requests refused while stalled, and writes that land in the same cycle as a request to the same descriptor, which tells a design that forwards the new contents apart from one that uses the old ones.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_INVALID = 2'd1,
    CAUSE_BOUND   = 2'd2,
    CAUSE_PERM    = 2'd3
  } cause_e;

  localparam int PERM_BITS = 3;
  localparam int PBIT_READ = 0;
  localparam int PBIT_WRITE = 1;
  localparam int PBIT_EXEC = 2;

  function automatic logic perm_allows(input acc_e acc, input logic [PERM_BITS-1:0] perm);
    case (acc)
      ACC_READ:  perm_allows = perm[PBIT_READ];
      ACC_WRITE: perm_allows = perm[PBIT_WRITE];
      ACC_FETCH: perm_allows = perm[PBIT_EXEC];
      default:   perm_allows = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int BASE_W = 32,
  parameter int OFF_W = 20,
  localparam int SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic                 wr_valid,
  input  logic [PERM_BITS-1:0] wr_perm,
  input  logic [BASE_W-1:0]    wr_base,
  input  logic [OFF_W-1:0]     wr_bound,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic                 rd_valid,
  output logic [PERM_BITS-1:0] rd_perm,
  output logic [BASE_W-1:0]    rd_base,
  output logic [OFF_W-1:0]     rd_bound
);
  logic [NUM_SEG-1:0]   valid_q;
  logic [PERM_BITS-1:0] perm_q  [NUM_SEG];
  logic [BASE_W-1:0]    base_q  [NUM_SEG];
  logic [OFF_W-1:0]     bound_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));

    // Valid flag: reset to unusable.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (hit) begin
        valid_q[g] <= wr_valid;
      end
    end

    // Payload: no reset, written only on enable.
    always_ff @(posedge clk) begin
      if (hit) begin
        perm_q[g]  <= wr_perm;
        base_q[g]  <= wr_base;
        bound_q[g] <= wr_bound;
      end
    end
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_perm  = '0;
    rd_base  = '0;
    rd_bound = '0;
    if (32'(rd_sel) < NUM_SEG) begin
      rd_valid = valid_q[rd_sel];
      rd_perm  = perm_q[rd_sel];
      rd_base  = base_q[rd_sel];
      rd_bound = bound_q[rd_sel];
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int OFF_W = 20
) (
  input  logic                 d_valid,
  input  logic [PERM_BITS-1:0] d_perm,
  input  logic [BASE_W-1:0]    d_base,
  input  logic [OFF_W-1:0]     d_bound,
  input  logic [OFF_W-1:0]     off,
  input  logic [1:0]           acc,
  output logic [BASE_W-1:0]    addr,
  output logic [1:0]           cause
);
  logic over_limit;
  logic perm_ok;

  assign over_limit = off > d_bound;
  assign perm_ok    = perm_allows(acc_e'(acc), d_perm);

  // Fault priority: invalid, then limit, then permission.
  always_comb begin
    cause = CAUSE_NONE;
    addr  = '0;
    if (!d_valid) begin
      cause = CAUSE_INVALID;
    end else if (over_limit) begin
      cause = CAUSE_BOUND;
    end else if (!perm_ok) begin
      cause = CAUSE_PERM;
    end else begin
      addr = d_base + BASE_W'(off);
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 8,
  parameter int BASE_W = 32,
  parameter int OFF_W = 20,
  localparam int SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEL_W-1:0]     req_sel,
  input  logic [OFF_W-1:0]     req_off,
  input  logic [1:0]           req_acc,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [BASE_W-1:0]    rsp_addr,
  output logic                 rsp_fault,
  output logic [1:0]           rsp_cause,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_sel,
  input  logic                 wr_valid,
  input  logic [PERM_BITS-1:0] wr_perm,
  input  logic [BASE_W-1:0]    wr_base,
  input  logic [OFF_W-1:0]     wr_bound
);
  logic                 d_valid;
  logic [PERM_BITS-1:0] d_perm;
  logic [BASE_W-1:0]    d_base;
  logic [OFF_W-1:0]     d_bound;
  logic [BASE_W-1:0]    xl_addr;
  logic [1:0]           xl_cause;

  logic                 vld_q, vld_d;
  logic                 load;
  logic [BASE_W-1:0]    addr_q;
  logic [1:0]           cause_q;

  seg_desc_table #(.NUM_SEG(NUM_SEG), .BASE_W(BASE_W), .OFF_W(OFF_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_valid (wr_valid),
    .wr_perm  (wr_perm),
    .wr_base  (wr_base),
    .wr_bound (wr_bound),
    .rd_sel   (req_sel),
    .rd_valid (d_valid),
    .rd_perm  (d_perm),
    .rd_base  (d_base),
    .rd_bound (d_bound)
  );

  seg_check #(.BASE_W(BASE_W), .OFF_W(OFF_W)) u_check (
    .d_valid (d_valid),
    .d_perm  (d_perm),
    .d_base  (d_base),
    .d_bound (d_bound),
    .off     (req_off),
    .acc     (req_acc),
    .addr    (xl_addr),
    .cause   (xl_cause)
  );

  assign req_ready = !vld_q || rsp_ready;
  assign load      = req_valid && req_ready;

  always_comb begin
    vld_d = vld_q;
    if (load) begin
      vld_d = 1'b1;
    end else if (rsp_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        addr_q  <= xl_addr;
        cause_q <= xl_cause;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_addr  = addr_q;
  assign rsp_cause = cause_q;
  assign rsp_fault = cause_q != CAUSE_NONE;
endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [BASE_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic [1:0]        rsp_cause
);
  // R6: an accepted request yields a response in the next cycle
  assert_rsp_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R6: a stalled response holds its contents
  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_cause)));

  // R7: no acceptance while a response is stalled
  assert_no_accept_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9: a faulted response issues no address
  assert_fault_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_addr == '0));

  // R9: fault flag agrees with the cause code
  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != 2'd0)));

  // R6: a taken response with no new request retires
  assert_rsp_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_valid) |=> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_checker #(.BASE_W(BASE_W)) u_seg_xlate_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause)
);

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  localparam int NS = 8;
  localparam int BW = 32;
  localparam int OW = 20;
  localparam int SW = 3;

  logic clk, rst_n;
  logic req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault;
  logic [SW-1:0] req_sel, wr_sel;
  logic [OW-1:0] req_off, wr_bound;
  logic [1:0] req_acc, rsp_cause;
  logic [BW-1:0] rsp_addr, wr_base;
  logic wr_en, wr_valid;
  logic [2:0] wr_perm;

  seg_xlate #(.NUM_SEG(NS), .BASE_W(BW), .OFF_W(OW)) u_seg_xlate (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_tag = "R1";

  // Behavioural reference model
  bit          m_v [NS];
  bit [2:0]    m_p [NS];
  bit [BW-1:0] m_b [NS];
  bit [OW-1:0] m_l [NS];
  bit          e_valid;
  bit [BW-1:0] e_addr;
  bit [1:0]    e_cause;
  string       e_tag = "R5";

  function automatic void expect_of(input int s, input int off, input int acc,
                                    output bit [BW-1:0] a, output bit [1:0] c);
    bit ok;
    a = 0;
    ok = (acc == 0) ? m_p[s][0] : (acc == 1) ? m_p[s][1] : (acc == 2) ? m_p[s][2] : 1'b0;
    if (!m_v[s]) c = 1;
    else if (off > int'(m_l[s])) c = 2;
    else if (!ok) c = 3;
    else begin c = 0; a = m_b[s] + BW'(off); end
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) m_v[i] = 0;
      e_valid = 0;
    end else begin
      bit rdy;
      rdy = !e_valid || rsp_ready;
      if (req_valid && rdy) begin
        expect_of(int'(req_sel), int'(req_off), int'(req_acc), e_addr, e_cause);
        e_valid = 1;
        e_tag = cur_tag;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (wr_en) begin
        m_v[wr_sel] = wr_valid; m_p[wr_sel] = wr_perm;
        m_b[wr_sel] = wr_base;  m_l[wr_sel] = wr_bound;
      end
    end
  end

  task automatic chk(input bit cond, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Compare with the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (!e_valid || rsp_ready), "R7", "req_ready", req_ready, !e_valid || rsp_ready);
      chk(rsp_valid == e_valid, e_tag, "rsp_valid", rsp_valid, e_valid);
      if (e_valid && rsp_valid) begin
        chk(rsp_cause == e_cause, e_tag, "rsp_cause", rsp_cause, e_cause);
        chk(rsp_fault == (e_cause != 0), "R9", "rsp_fault", rsp_fault, e_cause != 0);
        chk(rsp_addr == e_addr, e_tag, "rsp_addr", rsp_addr, e_addr);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    req_valid = 0; wr_en = 0;
  endtask

  task automatic req(input int s, input int off, input int acc, input string tag);
    req_valid = 1; req_sel = SW'(s); req_off = OW'(off); req_acc = 2'(acc);
    cur_tag = tag;
    step();
    idle();
  endtask

  task automatic wr(input int s, input bit v, input int p, input int base, input int lim);
    wr_en = 1; wr_sel = SW'(s); wr_valid = v; wr_perm = 3'(p);
    wr_base = BW'(base); wr_bound = OW'(lim);
    step();
    idle();
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    step(); step();
    chk(rsp_valid == 0, "R5", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1;
    step();
  endtask

  initial begin
    rst_n = 0; rsp_ready = 1; idle();
    req_sel = 0; req_off = 0; req_acc = 0;
    wr_sel = 0; wr_valid = 0; wr_perm = 0; wr_base = 0; wr_bound = 0;
    do_reset();
    for (int s = 0; s < NS; s++) req(s, 0, 0, "R5");
    step();

    wr(0, 1, 3'b001, 32'h1000_0000, 20'h00FFF);
    wr(1, 1, 3'b111, 32'hFFFF_F000, 20'hFFFFF);
    wr(2, 1, 3'b010, 32'h0000_4000, 20'h00000);
    wr(7, 1, 3'b100, 32'h8000_0000, 20'h00100);
    req(0, 20'h00010, 0, "R1");
    req(0, 20'h00FFF, 0, "R2");
    req(0, 20'h01000, 0, "R2");
    req(0, 20'h00010, 1, "R3");
    req(0, 20'h00010, 2, "R3");
    req(1, 20'h00010, 3, "R3");
    req(7, 20'h00100, 2, "R3");
    req(7, 20'h00010, 0, "R3");
    req(1, 20'hFFFFF, 0, "R1");
    req(2, 20'h00000, 1, "R1");
    req(2, 20'h00001, 2, "R4");
    req(5, 20'hFFFFF, 3, "R4");
    step();

    // Stall: response held, offered requests refused
    rsp_ready = 0;
    req_valid = 1; req_sel = 0; req_off = 20'h00020; req_acc = 0; cur_tag = "R6";
    step();
    req_sel = 1; req_off = 20'h00030; cur_tag = "R7";
    step(); step(); step();
    rsp_ready = 1;
    step();
    idle(); step();

    // Same-cycle write and request to one descriptor
    wr_en = 1; wr_sel = 0; wr_valid = 1; wr_perm = 3'b011; wr_base = 32'h2000_0000; wr_bound = 20'h0000F;
    req_valid = 1; req_sel = 0; req_off = 20'h00100; req_acc = 0; cur_tag = "R8";
    step(); idle();
    req(0, 20'h00008, 1, "R8");
    req(0, 20'h00100, 0, "R8");
    wr(1, 0, 3'b111, 0, 20'hFFFFF);
    req(1, 20'h00000, 0, "R8");
    step();

    // Random phase: requests, back-pressure and writes against the model
    for (int i = 0; i < 3000; i++) begin
      req_valid = $urandom_range(0, 3) != 0;
      req_sel   = SW'($urandom);
      req_off   = ($urandom_range(0, 1) != 0) ? OW'($urandom_range(0, 64)) : OW'($urandom);
      req_acc   = 2'($urandom);
      rsp_ready = $urandom_range(0, 3) != 0;
      wr_en     = $urandom_range(0, 5) == 0;
      wr_sel    = SW'($urandom);
      wr_valid  = $urandom_range(0, 4) != 0;
      wr_perm   = 3'($urandom);
      wr_base   = BW'($urandom);
      wr_bound  = ($urandom_range(0, 1) != 0) ? OW'($urandom_range(0, 64)) : OW'($urandom);
      cur_tag   = "R6";
      step();
    end
    idle(); rsp_ready = 1;
    step(); step();

    // Reset mid-run clears all descriptors
    do_reset();
    for (int s = 0; s < NS; s++) req(s, 0, 2, "R5");
    step(); step();

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule